// File: doc/BRIEF.md
# Sync-Aligned Receive Bit Gate

This block sits between a serial receiver front end and the protocol engine. It decides, one serial bit at a time, whether a received bit goes on to the engine or is dropped. A frame begins when the sync line moves into its active level. From that bit onward, a programmed delay in bit times passes. Then a small run-length map is walked from entry 0. Each map entry accepts or rejects every bit it covers, and it covers a span counted either in single bits or in 8-bit bytes.

Software-side logic loads the map one entry per cycle through a write port. The sync polarity, the delay and the index of the last used entry are supplied as quasi-static configuration inputs. For every input bit, the block produces one registered result one clock after the bit is sampled: an accept strobe, the accepted data bit, and a one-cycle pulse that marks the final bit of the frame. A parameter selects whether data and sync are captured on the rising edge or the falling edge of the serial clock.

Top module: `rx_bit_gate`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into map entry `cfg_addr`. The entry fields are bit 7 = accept flag, bit 6 = unit select (1 = bytes, 0 = bits) and bits 5:0 = count, where the span is count+1 units.
- R2: A sync event is a cycle in which the sync line is at its active level and was not at it on the previous sampled bit. The active level is high when `cfg_sync_high` is 1 and low when it is 0.
- R3: With `cfg_delay` of 0, map entry 0 governs the bit sampled together with the sync event. Every bit's result appears on the outputs one clock after that bit is sampled.
- R4: With `cfg_delay` = D > 0, the sync bit and the D-1 bits after it are rejected, and entry 0 governs bit D counted from the sync bit (bit 0).
- R5: An entry with unit select 0 governs exactly count+1 consecutive bits, and the next entry governs the bit that follows them.
- R6: An entry with unit select 1 governs exactly 8*(count+1) consecutive bits. For example, with a delay of 1 and count 13, entry 0 covers bits 1 through 112.
- R7: For a bit governed by an accepting entry, `acc_valid` is 1 and `acc_data` equals the sampled data bit. For every rejected bit, both `acc_valid` and `acc_data` are 0.
- R8: `frame_end` pulses for one cycle together with the result of the final bit of entry `cfg_last`. After that, every bit is rejected until the next sync event.
- R9: A sync event during the delay or during a map walk abandons the current frame without `frame_end` and restarts the delay and the map at entry 0.
- R10: After reset, `acc_valid`, `acc_data` and `frame_end` are 0, no frame is active, and every map entry reads as reject, bit unit, count 0.
- R11: Holding the sync line at its active level for many bits produces only a single sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial receive data bit |
| ser_sync | input | 1 | Frame sync line |
| cfg_sync_high | input | 1 | 1 = sync active high, 0 = active low |
| cfg_delay | input | 4 | Bit times from sync to the start of entry 0 |
| cfg_last | input | 4 | Index of the last map entry in a frame |
| cfg_we | input | 1 | Map entry write strobe |
| cfg_addr | input | 4 | Map entry index to write |
| cfg_wdata | input | 8 | Entry: accept, unit select, 6-bit count |
| acc_valid | output | 1 | Current result bit is accepted |
| acc_data | output | 1 | Accepted data bit (0 when rejected) |
| frame_end | output | 1 | One-cycle pulse on the last bit of the frame |

## Verification
The bench aims at the delay boundary: a design off by one there would accept the sync bit itself when the delay is 1, or start entry 0 a bit late. It also drives spans at both extremes, a single bit and a 512-bit byte span. A wrong multiplier or a missing wrap of the position counter would shift every later entry. Sync pulses are placed mid-walk and mid-delay, where a design that ignored the restart would keep accepting under the old entry or raise a stray end-of-frame pulse. Long active sync levels and the low-active polarity are also exercised, where level-triggered detection would restart the frame on every bit.

// File: rtl/rxgate_pkg.sv
package rxgate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } gate_st_e;
endpackage

// File: rtl/rxg_span_end.sv
// Flags the final bit position of a map entry's span.
module rxg_span_end #(
    parameter int CNT_W   = 6,
    parameter int BYTE_LG = 3,
    localparam int POS_W  = CNT_W + BYTE_LG
) (
    input  logic             unit_bytes,
    input  logic [CNT_W-1:0] count,
    input  logic [POS_W-1:0] pos,
    output logic             last_bit
);
    logic [POS_W-1:0] cnt_ext;
    logic [POS_W-1:0] span_m1;

    always_comb begin
        cnt_ext = POS_W'(count);
        if (unit_bytes) begin
            span_m1 = ((cnt_ext + POS_W'(1)) << BYTE_LG) - POS_W'(1);
        end else begin
            span_m1 = cnt_ext;
        end
        last_bit = (pos == span_m1);
    end
endmodule

// File: rtl/rxg_map.sv
// Run-length acceptance map: one write port, one combinational read port.
module rxg_map #(
    parameter int ENTRIES = 16,
    parameter int EW      = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [EW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [EW-1:0]    rdata
);
    logic [EW-1:0] ents [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [EW-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (waddr == IDX_W'(i))) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ents[i] = ent_q;
    end

    assign rdata = ents[raddr];

    // R1: a written entry holds the written value on the next cycle
    p_map_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ents[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rx_bit_gate.sv
module rx_bit_gate #(
    parameter int ENTRIES     = 16,
    parameter int CNT_W       = 6,
    parameter int DLY_W       = 4,
    parameter int BYTE_LG     = 3,
    parameter bit SAMPLE_FALL = 1'b0,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int EW         = CNT_W + 2,
    localparam int POS_W      = CNT_W + BYTE_LG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_din,
    input  logic             ser_sync,
    input  logic             cfg_sync_high,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [IDX_W-1:0] cfg_last,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [EW-1:0]    cfg_wdata,
    output logic             acc_valid,
    output logic             acc_data,
    output logic             frame_end
);
    import rxgate_pkg::*;

    typedef struct packed {
        gate_st_e         st;
        logic [DLY_W-1:0] rem;
        logic [IDX_W-1:0] ent;
        logic [POS_W-1:0] pos;
        logic             act_prev;
        logic             vld;
        logic             dat;
        logic             eof;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // ---------------- input sampling edge ----------------
    logic din_s, sync_s;

    if (SAMPLE_FALL) begin : g_fall
        logic din_q, sync_q;
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                din_q  <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                din_q  <= ser_din;
                sync_q <= ser_sync;
            end
        end
        assign din_s  = din_q;
        assign sync_s = sync_q;
    end else begin : g_rise
        assign din_s  = ser_din;
        assign sync_s = ser_sync;
    end

    // ---------------- map and span decode ----------------
    logic [IDX_W-1:0] use_ent;
    logic [POS_W-1:0] use_pos;
    logic [EW-1:0]    ent_rd;
    logic             ent_accept, ent_bytes, span_last;
    logic [CNT_W-1:0] ent_count;

    rxg_map #(.ENTRIES(ENTRIES), .EW(EW)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (use_ent),
        .rdata (ent_rd)
    );

    assign ent_accept = ent_rd[EW-1];
    assign ent_bytes  = ent_rd[EW-2];
    assign ent_count  = ent_rd[CNT_W-1:0];

    rxg_span_end #(.CNT_W(CNT_W), .BYTE_LG(BYTE_LG)) u_span (
        .unit_bytes (ent_bytes),
        .count      (ent_count),
        .pos        (use_pos),
        .last_bit   (span_last)
    );

    // ---------------- sequencer ----------------
    logic sync_act, sync_evt, run_now;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        ctl_d.dat = 1'b0;
        ctl_d.eof = 1'b0;

        sync_act       = (sync_s == cfg_sync_high);
        sync_evt       = sync_act && !ctl_q.act_prev;
        ctl_d.act_prev = sync_act;

        run_now = 1'b0;
        use_ent = ctl_q.ent;
        use_pos = ctl_q.pos;

        if (sync_evt) begin
            if (cfg_delay == '0) begin
                run_now = 1'b1;
                use_ent = '0;
                use_pos = '0;
            end else begin
                ctl_d.st  = ST_WAIT;
                ctl_d.rem = cfg_delay - DLY_W'(1);
            end
        end else begin
            unique case (ctl_q.st)
                ST_WAIT: begin
                    if (ctl_q.rem == '0) begin
                        run_now = 1'b1;
                        use_ent = '0;
                        use_pos = '0;
                    end else begin
                        ctl_d.rem = ctl_q.rem - DLY_W'(1);
                    end
                end
                ST_RUN:  run_now = 1'b1;
                default: ;
            endcase
        end

        if (run_now) begin
            ctl_d.vld = ent_accept;
            ctl_d.dat = ent_accept & din_s;
            if (span_last) begin
                ctl_d.pos = '0;
                if (use_ent == cfg_last) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.ent = '0;
                    ctl_d.eof = 1'b1;
                end else begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.ent = use_ent + IDX_W'(1);
                end
            end else begin
                ctl_d.st  = ST_RUN;
                ctl_d.ent = use_ent;
                ctl_d.pos = use_pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign acc_valid = ctl_q.vld;
    assign acc_data  = ctl_q.dat;
    assign frame_end = ctl_q.eof;

    // ---------------- assertions ----------------
    // R8: with no frame active and no sync, nothing is accepted
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !sync_evt) |=> !acc_valid);

    // R8: the end pulse leaves the sequencer idle
    p_eof_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (ctl_q.st == ST_IDLE));

    // R4: bits inside the delay window are rejected
    p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && ctl_q.rem != '0 && !sync_evt) |=> !acc_valid);

    // R9: a sync with nonzero delay drops the bit and ends no frame
    p_sync_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && cfg_delay != '0) |=> (!acc_valid && !frame_end));

    // R7: an accepted bit carries the sampled data
    p_data_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_data == $past(din_s)));

    // R7: rejected bits never show data
    p_data_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_data);

    // R11: an active level already seen cannot raise a new event
    p_level_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_act && $past(sync_act) && $past(cfg_sync_high) == cfg_sync_high
         && $past(rst_n)) |-> !sync_evt);
endmodule

// File: tb/sim_rx_bit_gate.sv
`timescale 1ns/1ps
module sim_rx_bit_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_sync = 1'b0;
    logic       cfg_sync_high = 1'b1;
    logic [3:0] cfg_delay = 4'd0;
    logic [3:0] cfg_last = 4'd0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = 4'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       acc_valid, acc_data, frame_end;

    always #2 clk = ~clk;   // 250 MHz

    rx_bit_gate u0 (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_sync(ser_sync),
        .cfg_sync_high(cfg_sync_high), .cfg_delay(cfg_delay), .cfg_last(cfg_last),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_data(acc_data), .frame_end(frame_end)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    // behavioural reference state
    int   m_state = 0;   // 0 idle, 1 delay, 2 walking
    int   m_rem = 0;
    int   m_ent = 0;
    int   m_pos = 0;
    bit   m_prev = 0;
    bit [7:0] m_map [16];
    int   acc_count = 0;
    int   eof_count = 0;

    task automatic check3(bit ev, bit ed, bit ee);
        checks++;
        if (acc_valid !== ev || acc_data !== ed || frame_end !== ee) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%0b end=%0b expected valid=%0b data=%0b end=%0b",
                     cur_req, acc_valid, acc_data, frame_end, ev, ed, ee);
        end
    endtask

    // one bit time: drive, predict, sample after the edge
    task automatic step(bit d, bit s);
        bit act, evt, run, ev, ed, ee;
        int e, p, span;
        @(negedge clk);
        ser_din  = d;
        ser_sync = s;
        act = (s == cfg_sync_high);
        evt = act && !m_prev;
        m_prev = act;
        run = 0; e = 0; p = 0;
        ev = 0; ed = 0; ee = 0;
        if (evt) begin
            if (cfg_delay == 0) run = 1;
            else begin m_state = 1; m_rem = cfg_delay - 1; end
        end else if (m_state == 1) begin
            if (m_rem == 0) run = 1; else m_rem--;
        end else if (m_state == 2) begin
            run = 1; e = m_ent; p = m_pos;
        end
        if (run) begin
            span = (m_map[e][5:0] + 1) * (m_map[e][6] ? 8 : 1);
            ev = m_map[e][7];
            ed = ev & d;
            if (p == span - 1) begin
                if (e == cfg_last) begin m_state = 0; ee = 1; end
                else begin m_state = 2; m_ent = e + 1; m_pos = 0; end
            end else begin
                m_state = 2; m_ent = e; m_pos = p + 1;
            end
        end
        if (cfg_we) m_map[cfg_addr] = cfg_wdata;
        @(posedge clk);
        #1;
        check3(ev, ed, ee);
        if (acc_valid) acc_count++;
        if (frame_end) eof_count++;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step(1'($urandom), ~cfg_sync_high);
    endtask

    // R1: load one map entry through the write port
    task automatic wr(int a, bit acc, bit bytes, int cnt);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = {acc, bytes, 6'(cnt)};
        step(1'b0, ~cfg_sync_high);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sync_pulse();
        step(1'($urandom), cfg_sync_high);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_map[i] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state of the outputs
        cur_req = "R10";
        check3(0, 0, 0);
        // R10: cleared map rejects and ends after one bit
        sync_pulse();
        quiet(4);

        // R1 R3 R5: bit-unit entries, delay 0
        cur_req = "R5";
        wr(0, 1, 0, 2);
        wr(1, 0, 0, 0);
        wr(2, 1, 0, 1);
        cfg_last = 4'd2;
        cfg_delay = 4'd0;
        sync_pulse();
        quiet(10);
        cur_req = "R3";
        sync_pulse();
        quiet(8);

        // R4: nonzero delays
        cur_req = "R4";
        cfg_delay = 4'd3;
        sync_pulse();
        quiet(12);
        cfg_delay = 4'd15;
        sync_pulse();
        quiet(25);

        // R6: byte spans, 14 bytes after a delay of 1
        cur_req = "R6";
        wr(0, 1, 1, 13);
        wr(1, 0, 0, 0);
        cfg_last = 4'd1;
        cfg_delay = 4'd1;
        acc_count = 0;
        sync_pulse();
        quiet(130);
        checks++;
        if (acc_count != 112) begin
            errors++;
            $display("FAIL R6: got %0d accepted bits expected 112", acc_count);
        end
        // R6: widest span of 64 bytes
        wr(0, 1, 1, 63);
        cfg_delay = 4'd0;
        sync_pulse();
        quiet(530);

        // R9: sync mid-walk and mid-delay
        cur_req = "R9";
        wr(0, 1, 0, 9);
        wr(1, 1, 1, 1);
        cfg_delay = 4'd2;
        eof_count = 0;
        sync_pulse();
        quiet(6);
        sync_pulse();
        quiet(1);
        sync_pulse();
        quiet(40);
        checks++;
        if (eof_count != 1) begin
            errors++;
            $display("FAIL R9: got %0d end pulses expected 1", eof_count);
        end

        // R2: active-low sync
        cur_req = "R2";
        cfg_sync_high = 1'b0;
        quiet(3);
        sync_pulse();
        quiet(35);
        cfg_sync_high = 1'b1;
        quiet(3);

        // R11: long active level triggers once
        cur_req = "R11";
        cfg_delay = 4'd0;
        eof_count = 0;
        for (int i = 0; i < 60; i++) step(1'($urandom), 1'b1);
        quiet(4);
        checks++;
        if (eof_count != 1) begin
            errors++;
            $display("FAIL R11: got %0d end pulses expected 1", eof_count);
        end

        // R7 R8: all sixteen entries, alternating, then idle
        cur_req = "R8";
        for (int i = 0; i < 16; i++) wr(i, i[0], 0, i % 3);
        cfg_last = 4'd15;
        cfg_delay = 4'd1;
        sync_pulse();
        quiet(50);
        cur_req = "R7";
        sync_pulse();
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule